// File: doc/BRIEF.md
# Sequential Code Lock Controller

This block is a three-digit combination lock. Three 4-bit secret digits arrive on a packed configuration port. The user presents digits one at a time on a small valid/ready input stream. A one-hot multiplexer picks the stored digit for the current position. An equality comparator checks the presented digit against it. A controller then steps through the positions.

The controller is output-encoded: its flip-flops are the outputs. The low bits form the one-hot position select, which drives the multiplexer. The top bit is the unlock flag. The all-zero pattern marks a failed attempt.

After three matching digits in order, the lock opens and stays open. A wrong digit at any position drops the lock into the failed state, which it keeps. Only reset leaves either the open state or the failed state. The digit stream never applies back-pressure.

Top module: `seqlock_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `pos_sel` to 3'b001 (bit 0 = first digit) and `unlocked` to 0 from the following cycle.
- R2: When `digit_valid` is high and the presented digit equals the stored digit chosen by the one-hot `pos_sel`, the set bit moves one place up at the next edge: 001→010→100. From 100, `unlocked` rises and `pos_sel` becomes 000.
- R3: In a cycle with `digit_valid` low, `pos_sel` and `unlocked` keep their values.
- R4: When `digit_valid` is high at any position and the digit differs from the selected stored digit, the next state is the failed state: `pos_sel` = 000 and `unlocked` = 0.
- R5: The failed state is kept regardless of any digits presented, until reset.
- R6: Once `unlocked` is 1, it stays 1 with `pos_sel` = 000 regardless of further digits, until reset.
- R7: At most one bit of {`unlocked`, `pos_sel`} is ever high.
- R8: `digit_ready` is always high. A digit is consumed in every cycle in which `digit_valid` is high, so the sender is never stalled.
- R9: The stored digits are packed into `code_table`, with the first digit in bits [3:0], the second in [7:4] and the third in [11:8]. Each position compares against its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| code_table | input | 12 | Stored digits; first digit in the low nibble |
| digit_valid | input | 1 | Digit present on `digit_value` this cycle |
| digit_ready | output | 1 | Always high; the block accepts a digit every cycle |
| digit_value | input | 4 | Presented digit |
| pos_sel | output | 3 | One-hot position select, taken directly from state flops |
| unlocked | output | 1 | Lock open flag, taken directly from a state flop |

## Verification
The state flops are the outputs, so any corrupted state shows on `pos_sel` or `unlocked` in the same cycle it arises. Nothing hides the state. A stray second bit, a lost bit or an early unlock breaks the one-hot rule or the expected step pattern. This appears on the cycle right after the accepted digit that caused it. A failed or open state that leaks shows up as a change on the first later digit.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
  localparam int unsigned DIGIT_W_DEF    = 4;
  localparam int unsigned NUM_DIGITS_DEF = 3;

  // Reset pattern: first position selected, lock closed.
  function automatic logic [NUM_DIGITS_DEF:0] reset_state();
    reset_state = '0;
    reset_state[0] = 1'b1;
  endfunction
endpackage

// File: rtl/seqlock_mux.sv
module seqlock_mux #(
  parameter int unsigned DIGIT_W    = seqlock_pkg::DIGIT_W_DEF,
  parameter int unsigned NUM_DIGITS = seqlock_pkg::NUM_DIGITS_DEF
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] codes,
  input  logic [NUM_DIGITS-1:0]         sel,
  output logic [DIGIT_W-1:0]            picked
);
  logic [DIGIT_W-1:0] gated [NUM_DIGITS];

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_gate
      assign gated[g] = codes[g*DIGIT_W +: DIGIT_W] & {DIGIT_W{sel[g]}};
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      picked = picked | gated[i];
    end
  end
endmodule

// File: rtl/seqlock_cmp.sv
module seqlock_cmp #(
  parameter int unsigned DIGIT_W = seqlock_pkg::DIGIT_W_DEF
) (
  input  logic [DIGIT_W-1:0] lhs,
  input  logic [DIGIT_W-1:0] rhs,
  output logic               same
);
  logic [DIGIT_W-1:0] diff;
  assign diff = lhs ^ rhs;
  assign same = ~|diff;
endmodule

// File: rtl/seqlock_ctrl.sv
module seqlock_ctrl #(
  parameter int unsigned NUM_DIGITS = seqlock_pkg::NUM_DIGITS_DEF,
  localparam int unsigned SW = NUM_DIGITS + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          hit,
  output logic [SW-1:0] state_q
);
  logic [SW-1:0] state_d;
  logic          adv;

  assign adv = step & hit;

  // Per-bit next state: each stage takes the token from below on an accepted
  // match and keeps its own token while idle. The top (open) bit is sticky.
  genvar b;
  generate
    for (b = 0; b < SW; b++) begin : g_next
      if (b == 0) begin : g_first
        assign state_d[b] = state_q[b] & ~step;
      end else if (b == SW - 1) begin : g_open
        assign state_d[b] = (state_q[b-1] & adv) | state_q[b];
      end else begin : g_mid
        assign state_d[b] = (state_q[b-1] & adv) | (state_q[b] & ~step);
      end
    end
  endgenerate

  // Reset acts as preset on bit 0 and clear on the rest, bypassing next-state logic.
  generate
    for (b = 0; b < SW; b++) begin : g_flop
      if (b == 0) begin : g_preset
        always_ff @(posedge clk) begin
          if (rst) state_q[b] <= 1'b1;
          else     state_q[b] <= state_d[b];
        end
      end else begin : g_clear
        always_ff @(posedge clk) begin
          if (rst) state_q[b] <= 1'b0;
          else     state_q[b] <= state_d[b];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/seqlock_top.sv
module seqlock_top #(
  parameter int unsigned DIGIT_W    = seqlock_pkg::DIGIT_W_DEF,
  parameter int unsigned NUM_DIGITS = seqlock_pkg::NUM_DIGITS_DEF,
  localparam int unsigned CODE_W = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_W-1:0]     code_table,
  input  logic                  digit_valid,
  output logic                  digit_ready,
  input  logic [DIGIT_W-1:0]    digit_value,
  output logic [NUM_DIGITS-1:0] pos_sel,
  output logic                  unlocked
);
  logic [NUM_DIGITS:0] state_q;
  logic [DIGIT_W-1:0]  ref_digit;
  logic                match;

  assign digit_ready = 1'b1;
  assign pos_sel     = state_q[NUM_DIGITS-1:0];
  assign unlocked    = state_q[NUM_DIGITS];

  seqlock_mux #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) mux_i (
    .codes (code_table),
    .sel   (pos_sel),
    .picked(ref_digit)
  );

  seqlock_cmp #(.DIGIT_W(DIGIT_W)) cmp_i (
    .lhs (digit_value),
    .rhs (ref_digit),
    .same(match)
  );

  seqlock_ctrl #(.NUM_DIGITS(NUM_DIGITS)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .step   (digit_valid & digit_ready),
    .hit    (match),
    .state_q(state_q)
  );
endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk #(
  parameter int unsigned DIGIT_W    = seqlock_pkg::DIGIT_W_DEF,
  parameter int unsigned NUM_DIGITS = seqlock_pkg::NUM_DIGITS_DEF
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_DIGITS*DIGIT_W-1:0] code_table,
  input logic                          digit_valid,
  input logic                          digit_ready,
  input logic [DIGIT_W-1:0]            digit_value,
  input logic [NUM_DIGITS-1:0]         pos_sel,
  input logic                          unlocked
);
  logic hit_exp;
  always_comb begin
    hit_exp = 1'b0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (pos_sel[i] && code_table[i*DIGIT_W +: DIGIT_W] == digit_value) hit_exp = 1'b1;
    end
  end

  logic [NUM_DIGITS:0] full;
  assign full = {unlocked, pos_sel};

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (full == seqlock_pkg::reset_state())); // R1
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (digit_valid && |pos_sel && hit_exp) |=> (full == ($past(full) << 1))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !digit_valid |=> ($stable(pos_sel) && $stable(unlocked))); // R3
  AST_MISS_FAIL: assert property (@(posedge clk) disable iff (rst)
    (digit_valid && |pos_sel && !hit_exp) |=> (full == '0)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full == '0) |=> (full == '0)); // R5
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> (unlocked && pos_sel == '0)); // R6
  AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(full)); // R7
  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    digit_ready); // R8
endmodule

bind seqlock_top seqlock_chk #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk(clk), .rst(rst), .code_table(code_table), .digit_valid(digit_valid),
  .digit_ready(digit_ready), .digit_value(digit_value), .pos_sel(pos_sel),
  .unlocked(unlocked)
);

// File: tb/seqlock_top_tb_top.sv
module seqlock_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] code_table = 12'hC93;
  logic        digit_valid = 1'b0;
  logic        digit_ready;
  logic [3:0]  digit_value = '0;
  logic [2:0]  pos_sel;
  logic        unlocked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  seqlock_top dut_i (
    .clk(clk), .rst(rst), .code_table(code_table), .digit_valid(digit_valid),
    .digit_ready(digit_ready), .digit_value(digit_value), .pos_sel(pos_sel),
    .unlocked(unlocked)
  );

  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {unlocked, pos_sel};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {unlocked,pos_sel} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; digit_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    expect_out("R1", 4'b0001);
  endtask

  task automatic send(input logic [3:0] d);
    @(negedge clk); digit_valid = 1'b1; digit_value = d;
    checks++;
    if (digit_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8: digit_ready actual=%b expected=1", digit_ready);
    end
    @(negedge clk); digit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_good_sequence();
    do_reset();
    send(4'h3); expect_out("R2 R9", 4'b0010);
    send(4'h9); expect_out("R2 R9", 4'b0100);
    send(4'hC); expect_out("R2 R6", 4'b1000);
  endtask

  task automatic t_idle_gaps();
    do_reset();
    idle(3); expect_out("R3", 4'b0001);
    send(4'h3); idle(4); expect_out("R3", 4'b0010);
    send(4'h9); idle(2); expect_out("R3", 4'b0100);
    send(4'hC); idle(2); expect_out("R3 R6", 4'b1000);
  endtask

  task automatic t_wrong_at(input int pos);
    logic [3:0] good [3];
    good[0] = 4'h3; good[1] = 4'h9; good[2] = 4'hC;
    do_reset();
    for (int i = 0; i < pos; i++) send(good[i]);
    send(good[pos] ^ 4'h1);
    expect_out("R4", 4'b0000);
    // Correct continuation must not revive the attempt.
    for (int i = 0; i < 3; i++) begin
      send(good[i]); expect_out("R5", 4'b0000);
    end
  endtask

  task automatic t_extra_after_open();
    t_good_sequence();
    send(4'h0); expect_out("R6", 4'b1000);
    send(4'h3); expect_out("R6", 4'b1000);
    send(4'hC); expect_out("R6", 4'b1000);
  endtask

  task automatic t_new_codes();
    code_table = 12'h05A;
    do_reset();
    send(4'h3); expect_out("R9", 4'b0000);
    do_reset();
    send(4'hA); expect_out("R9", 4'b0010);
    send(4'h5); expect_out("R9", 4'b0100);
    send(4'h0); expect_out("R9", 4'b1000);
    code_table = 12'hC93;
  endtask

  task automatic t_reset_from_open();
    t_good_sequence();
    do_reset();
    send(4'h3); expect_out("R1 R2", 4'b0010);
  endtask

  // R7: sampled away from the clock edge on every cycle.
  always @(negedge clk) begin
    if (!rst && !done && $countones({unlocked, pos_sel}) > 1) begin
      checks++; fails++;
      $display("FAIL R7: {unlocked,pos_sel} actual=%b expected=at most one bit",
               {unlocked, pos_sel});
    end
  end

  initial begin
    idle(2);
    t_good_sequence();
    t_idle_gaps();
    t_wrong_at(0);
    t_wrong_at(1);
    t_wrong_at(2);
    t_extra_after_open();
    t_new_codes();
    t_reset_from_open();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule